// File: doc/BRIEF.md
# Load-Use Hazard Stall Controller

This block sits in the decode stage of a five-stage in-order pipeline. It compares the destination register of a load that is now in execute with the source registers of the instruction waiting in decode. When they collide, the block holds the fetch and decode stages for one cycle and sends a no-op down the pipe in place of the dependent instruction. When the stall releases, the dependent instruction issues, and forwarding supplies the loaded value.

The block includes the control part of the decode-to-execute pipeline register. This shows the bubble directly: in the stall cycle the decode-stage control bits are gated to zero before they are registered. Instructions already past decode keep moving. Because the gated bubble carries a cleared memory-read flag, the stall condition goes false on the next cycle by itself.

Top module: `luh_stall_ctrl`

## Requirements
- R1: A stall is raised when the execute-stage control has memory-read set, the decode instruction's first source use flag is set, and its first source register equals the execute-stage destination register `ex_rt`.
- R2: A stall is raised when the execute-stage control has memory-read set, the second source use flag is set, and the second source register equals `ex_rt`.
- R3: No stall is raised while the execute-stage memory-read flag is clear, even if the register numbers match.
- R4: A source whose use flag is clear is never compared. A match on that source alone raises no stall.
- R5: While a stall is raised, `pc_we` and `ifid_we` are 0 and `ctrl_zero_sel` is 1. Otherwise they are 1, 1 and 0.
- R6: On the clock edge of a stall cycle, every execute-stage control output becomes 0. `ex_rt` still loads the decode instruction's second source register.
- R7: On a clock edge without a stall, the execute-stage control outputs load the decode control inputs unchanged.
- R8: With the decode inputs held, a stall lasts exactly one cycle. On the following edge the dependent instruction's control reaches execute.
- R9: While reset (`rst_n` low) is applied, all execute-stage control outputs and `ex_rt` are 0, and both write enables are 1.
- R10: A load whose destination matches neither used source raises no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs | input | REG_AW | Decode first source register |
| id_rt | input | REG_AW | Decode second source / load destination register |
| id_use_rs | input | 1 | Decode instruction reads first source |
| id_use_rt | input | 1 | Decode instruction reads second source |
| id_alu_op | input | 2 | Decode ALU operation class |
| id_alu_src | input | 1 | Decode ALU operand select |
| id_reg_dst | input | 1 | Decode destination select |
| id_mem_rd | input | 1 | Decode memory read |
| id_mem_wr | input | 1 | Decode memory write |
| id_reg_wr | input | 1 | Decode register write |
| id_mem_to_reg | input | 1 | Decode write-back source select |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero_sel | output | 1 | Select zeros for control entering execute |
| ex_alu_op | output | 2 | Execute ALU operation class |
| ex_alu_src | output | 1 | Execute ALU operand select |
| ex_reg_dst | output | 1 | Execute destination select |
| ex_mem_rd | output | 1 | Execute memory read |
| ex_mem_wr | output | 1 | Execute memory write |
| ex_reg_wr | output | 1 | Execute register write |
| ex_mem_to_reg | output | 1 | Execute write-back source select |
| ex_rt | output | REG_AW | Execute second source / destination register |

## Verification
Each scenario first loads a producer into execute, then presents a consumer in decode. The scenarios differ in one way each: a match on the first source, a match on the second source, a match on both, a match on register zero, no match, a match where the producer is not a load, and a match on a source whose use flag is clear. Comparing the load and non-load cases shows that the memory-read flag gates the stall. The use-flag case separates real operand reads from bit fields that only look like register numbers. In every stalled case, the bench checks the zeroed control in the cycle after the stall and the consumer's control in the cycle after that, which confirms that the stall lasts exactly one cycle.

// File: rtl/luh_pkg.sv
package luh_pkg;
    localparam int ALUOP_W = 2;

    typedef struct packed {
        logic [ALUOP_W-1:0] alu_op;
        logic               alu_src;
        logic               reg_dst;
        logic               mem_rd;
        logic               mem_wr;
        logic               reg_wr;
        logic               mem_to_reg;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/luh_detect.sv
module luh_detect #(
    parameter int REG_AW  = 5,
    parameter int N_SRC   = 2
) (
    input  logic                          ex_mem_rd,
    input  logic [REG_AW-1:0]             ex_rt,
    input  logic [N_SRC-1:0][REG_AW-1:0]  src_reg,
    input  logic [N_SRC-1:0]              src_use,
    output logic                          hazard
);
    logic [N_SRC-1:0] hit;

    // one comparator per decode source operand
    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        assign hit[g] = src_use[g] && (src_reg[g] == ex_rt);
    end

    assign hazard = ex_mem_rd && (|hit);
endmodule

// File: rtl/luh_ctrl_gate.sv
module luh_ctrl_gate
    import luh_pkg::*;
(
    input  ctrl_t ctrl_in,
    input  logic  zero_sel,
    output ctrl_t ctrl_out
);
    always_comb begin
        ctrl_out = zero_sel ? ctrl_t'('0) : ctrl_in;
    end
endmodule

// File: rtl/luh_idex_reg.sv
module luh_idex_reg
    import luh_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_in,
    input  logic [REG_AW-1:0] rt_in,
    input  logic              bubble,
    output ctrl_t             ctrl_q,
    output logic [REG_AW-1:0] rt_q
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [REG_AW-1:0] rt;
    } idex_t;

    idex_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ctrl = ctrl_in;
        st_d.rt   = rt_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;
    assign rt_q   = st_q.rt;

    assert_bubble_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (ctrl_q == ctrl_t'('0)));

    assert_rt_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rt_q == $past(rt_in)));

    assert_pass_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble |=> (ctrl_q == $past(ctrl_in)));
endmodule

// File: rtl/luh_stall_ctrl.sv
module luh_stall_ctrl
    import luh_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   id_rs,
    input  logic [REG_AW-1:0]   id_rt,
    input  logic                id_use_rs,
    input  logic                id_use_rt,
    input  logic [ALUOP_W-1:0]  id_alu_op,
    input  logic                id_alu_src,
    input  logic                id_reg_dst,
    input  logic                id_mem_rd,
    input  logic                id_mem_wr,
    input  logic                id_reg_wr,
    input  logic                id_mem_to_reg,
    output logic                pc_we,
    output logic                ifid_we,
    output logic                ctrl_zero_sel,
    output logic [ALUOP_W-1:0]  ex_alu_op,
    output logic                ex_alu_src,
    output logic                ex_reg_dst,
    output logic                ex_mem_rd,
    output logic                ex_mem_wr,
    output logic                ex_reg_wr,
    output logic                ex_mem_to_reg,
    output logic [REG_AW-1:0]   ex_rt
);
    localparam int N_SRC = 2;

    ctrl_t                        id_ctrl, gated_ctrl, ex_ctrl;
    logic [N_SRC-1:0][REG_AW-1:0] src_reg;
    logic [N_SRC-1:0]             src_use;
    logic                         stall;

    always_comb begin
        id_ctrl.alu_op     = id_alu_op;
        id_ctrl.alu_src    = id_alu_src;
        id_ctrl.reg_dst    = id_reg_dst;
        id_ctrl.mem_rd     = id_mem_rd;
        id_ctrl.mem_wr     = id_mem_wr;
        id_ctrl.reg_wr     = id_reg_wr;
        id_ctrl.mem_to_reg = id_mem_to_reg;
        src_reg[0]         = id_rs;
        src_reg[1]         = id_rt;
        src_use[0]         = id_use_rs;
        src_use[1]         = id_use_rt;
    end

    luh_detect #(.REG_AW(REG_AW), .N_SRC(N_SRC)) u_detect (
        .ex_mem_rd (ex_ctrl.mem_rd),
        .ex_rt     (ex_rt),
        .src_reg   (src_reg),
        .src_use   (src_use),
        .hazard    (stall)
    );

    luh_ctrl_gate u_gate (
        .ctrl_in  (id_ctrl),
        .zero_sel (stall),
        .ctrl_out (gated_ctrl)
    );

    luh_idex_reg #(.REG_AW(REG_AW)) u_idex (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_in (gated_ctrl),
        .rt_in   (id_rt),
        .bubble  (stall),
        .ctrl_q  (ex_ctrl),
        .rt_q    (ex_rt)
    );

    assign pc_we         = !stall;
    assign ifid_we       = !stall;
    assign ctrl_zero_sel = stall;

    assign ex_alu_op     = ex_ctrl.alu_op;
    assign ex_alu_src    = ex_ctrl.alu_src;
    assign ex_reg_dst    = ex_ctrl.reg_dst;
    assign ex_mem_rd     = ex_ctrl.mem_rd;
    assign ex_mem_wr     = ex_ctrl.mem_wr;
    assign ex_reg_wr     = ex_ctrl.reg_wr;
    assign ex_mem_to_reg = ex_ctrl.mem_to_reg;

    // a stall can only come from a load sitting in execute
    assert_load_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_mem_rd |-> (pc_we && ifid_we && !ctrl_zero_sel));

    // the bubble clears memory-read, so the stall cannot repeat
    assert_single_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero_sel |=> !ctrl_zero_sel);

    // the PC is released on the cycle after a stall
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pc_we) |=> pc_we);
endmodule

// File: tb/tb_luh_stall_ctrl.sv
module tb_luh_stall_ctrl;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] id_rs = '0, id_rt = '0;
    logic          id_use_rs = 1'b0, id_use_rt = 1'b0;
    logic [1:0]    id_alu_op = '0;
    logic          id_alu_src = 1'b0, id_reg_dst = 1'b0, id_mem_rd = 1'b0;
    logic          id_mem_wr = 1'b0, id_reg_wr = 1'b0, id_mem_to_reg = 1'b0;
    logic          pc_we, ifid_we, ctrl_zero_sel;
    logic [1:0]    ex_alu_op;
    logic          ex_alu_src, ex_reg_dst, ex_mem_rd, ex_mem_wr, ex_reg_wr, ex_mem_to_reg;
    logic [RW-1:0] ex_rt;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    luh_stall_ctrl #(.REG_AW(RW)) dut (
        .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt),
        .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .id_alu_op(id_alu_op),
        .id_alu_src(id_alu_src), .id_reg_dst(id_reg_dst), .id_mem_rd(id_mem_rd),
        .id_mem_wr(id_mem_wr), .id_reg_wr(id_reg_wr), .id_mem_to_reg(id_mem_to_reg),
        .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero_sel(ctrl_zero_sel),
        .ex_alu_op(ex_alu_op), .ex_alu_src(ex_alu_src), .ex_reg_dst(ex_reg_dst),
        .ex_mem_rd(ex_mem_rd), .ex_mem_wr(ex_mem_wr), .ex_reg_wr(ex_reg_wr),
        .ex_mem_to_reg(ex_mem_to_reg), .ex_rt(ex_rt)
    );

    // bench packing: {alu_op, alu_src, reg_dst, mem_rd, mem_wr, reg_wr, mem_to_reg}
    function automatic logic [7:0] ex_vec();
        return {ex_alu_op, ex_alu_src, ex_reg_dst, ex_mem_rd, ex_mem_wr, ex_reg_wr, ex_mem_to_reg};
    endfunction

    task automatic drive(input logic [7:0] c, input logic [RW-1:0] rs, input logic [RW-1:0] rt,
                         input logic urs, input logic urt);
        {id_alu_op, id_alu_src, id_reg_dst, id_mem_rd, id_mem_wr, id_reg_wr, id_mem_to_reg} = c;
        id_rs = rs; id_rt = rt; id_use_rs = urs; id_use_rt = urt;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance one edge; inputs change on the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    localparam logic [7:0] LOAD = 8'b00_1_0_1_0_1_1;
    localparam logic [7:0] ALU  = 8'b10_0_1_0_0_1_0;
    localparam logic [7:0] NOP  = 8'h00;

    // producer (load or not) writing prt, then consumer reading crs/crt
    task automatic run_pair(input string req, input logic [7:0] prod, input logic [RW-1:0] prt,
                            input logic [RW-1:0] crs, input logic [RW-1:0] crt,
                            input logic urs, input logic urt, input logic exp_stall);
        drive(NOP, '0, '0, 1'b0, 1'b0);
        step();
        drive(prod, 5'd9, prt, 1'b1, 1'b0);
        step();
        drive(ALU, crs, crt, urs, urt);
        #1;
        check({req, " R5 pc_we"}, pc_we, !exp_stall);
        check({req, " R5 ifid_we"}, ifid_we, !exp_stall);
        check({req, " R5 zero_sel"}, ctrl_zero_sel, exp_stall);
        step();
        if (exp_stall) begin
            check({req, " R6 bubble ctrl"}, ex_vec(), NOP);
            check({req, " R6 ex_rt loads"}, ex_rt, crt);
            check({req, " R8 released"}, pc_we, 1'b1);
            step();
            check({req, " R8 consumer issues"}, ex_vec(), ALU);
        end else begin
            check({req, " R7 consumer passes"}, ex_vec(), ALU);
        end
    endtask

    task automatic t_reset();
        drive(LOAD, 5'd3, 5'd3, 1'b1, 1'b1);
        @(negedge clk); @(negedge clk);
        check("R9 ctrl zero", ex_vec(), NOP);
        check("R9 ex_rt zero", ex_rt, '0);
        check("R9 pc_we", pc_we, 1'b1);
        check("R9 ifid_we", ifid_we, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic t_load_passes();
        drive(NOP, '0, '0, 1'b0, 1'b0);
        step();
        drive(LOAD, 5'd2, 5'd6, 1'b1, 1'b0);
        step();
        check("R7 load ctrl passes", ex_vec(), LOAD);
        check("R7 load rt", ex_rt, 5'd6);
    endtask

    initial begin
        t_reset();
        t_load_passes();
        run_pair("R1 rs match",      LOAD, 5'd4,  5'd4,  5'd7,  1'b1, 1'b1, 1'b1);
        run_pair("R2 rt match",      LOAD, 5'd12, 5'd1,  5'd12, 1'b1, 1'b1, 1'b1);
        run_pair("R2 both match",    LOAD, 5'd8,  5'd8,  5'd8,  1'b1, 1'b1, 1'b1);
        run_pair("R1 reg zero",      LOAD, 5'd0,  5'd0,  5'd3,  1'b1, 1'b1, 1'b1);
        run_pair("R3 not a load",    ALU,  5'd4,  5'd4,  5'd4,  1'b1, 1'b1, 1'b0);
        run_pair("R4 rt unused",     LOAD, 5'd11, 5'd2,  5'd11, 1'b1, 1'b0, 1'b0);
        run_pair("R4 rs unused",     LOAD, 5'd13, 5'd13, 5'd2,  1'b0, 1'b1, 1'b0);
        run_pair("R10 no match",     LOAD, 5'd20, 5'd21, 5'd22, 1'b1, 1'b1, 1'b0);
        run_pair("R1 top reg",       LOAD, 5'd31, 5'd31, 5'd30, 1'b1, 1'b1, 1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule